// File: doc/BRIEF.md
# Split-Access 64-Bit Register Bridge

This block holds a small bank of 64-bit registers behind a 32-bit register port. Each 64-bit register occupies two word addresses in big-endian word order: the word at the lower address of the pair carries bits 63..32, and the word at the higher address carries bits 31..0. Software updates a register in two cycles. The upper word is written first and is only staged. The write of the lower-half word then commits all 64 bits in a single clock edge, so no other logic ever sees a torn value.

Reads are split in the same way. Reading the upper word of a register captures the live lower half into a shadow. The read of the lower-half word that follows returns that shadow, so a free-running value such as the event counter gives a coherent pair even when it carries from one half into the other between the two reads. The bank holds a control register, a general scratch register and a 64-bit event counter. Setting the top bit of the control register's lower half starts a one-cycle soft reset of the rest of the bank.

Top module: `wide_reg_bridge`

## Requirements
- R1: After a hard reset every register reads as zero, `bus_rdata` is zero and `soft_rst_o` is low.
- R2: A write to a register's upper-half word (byte offset 0 within its 8-byte slot) stages the data only. The live register keeps its value.
- R3: A write to a register's lower-half word (byte offset 4) commits {staged word, written word} to that register in one clock edge.
- R4: The staged word clears after each commit. A lone lower-half write therefore commits zero in bits 63..32.
- R5: A read returns data in `bus_rdata` one cycle later. A read of offset 0 returns bits 63..32 and captures bits 31..0 of that register into a shadow.
- R6: A read of offset 4 while the shadow is valid returns the shadow, even if the live value has since changed, and invalidates the shadow. A later read of offset 4 returns the live bits 31..0.
- R7: A read of offset 4 with no shadow pending returns the live bits 31..0.
- R8: The counter (slot at 0x10) rises by exactly one on each clock edge at which `evt_i` is high, and holds otherwise.
- R9: A commit to the counter loads the committed value and takes precedence over an event in the same cycle.
- R10: A commit to the control register (slot at 0x00) with bit 31 of the lower half set raises `soft_rst_o` for exactly the next cycle. The pulse clears the scratch register and the counter, and an event during the pulse is lost. The control register keeps its other bits, and bit 31 reads back as zero afterwards.
- R11: In the control register's lower half only the bits in `CTRL_LO_MASK` (default 0x0000_00FF) are stored, and all other bits read zero. The upper half stores all 32 bits.
- R12: Word addresses outside the three slots read as zero. Writes to them change nothing, and that includes the staged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_rd | input | 1 | Read strobe for one 32-bit word |
| bus_addr | input | ADDR_W | Byte address (bit 2 selects the half, the bits above it select the slot) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| evt_i | input | 1 | Event pulse counted by the counter |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
The bench uses the default `ADDR_W` of 5 and the default control mask. With these values the three slots and one unmapped slot at 0x18 fit in the address space, so the tests reach both decode outcomes. The tests drive the counter across the 32-bit carry boundary between the two halves of a split read. This shows that the shadow gives a coherent pair. They also commit a counter load in the same cycle as an event and raise an event during the soft reset pulse, which checks both precedence rules.

// File: rtl/wide_reg_pkg.sv
package wide_reg_pkg;
  localparam int NUM_SLOTS  = 3;
  localparam int SLOT_CTRL  = 0;
  localparam int SLOT_SCR   = 1;
  localparam int SLOT_CNT   = 2;
  localparam int SRST_BIT   = 31;

  function automatic logic [63:0] join_halves(input logic [31:0] hi, input logic [31:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [31:0] upper_of(input logic [63:0] v);
    return v[63:32];
  endfunction

  function automatic logic [31:0] lower_of(input logic [63:0] v);
    return v[31:0];
  endfunction

  function automatic logic [31:0] ctrl_lo_keep(input logic [31:0] w, input logic [31:0] mask);
    logic [31:0] r;
    r = w & mask;
    r[SRST_BIT] = w[SRST_BIT];
    return r;
  endfunction
endpackage

// File: rtl/split_stage.sv
module split_stage #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              commit_o,
  output logic [ADDR_W-4:0] commit_idx_o,
  output logic [63:0]       commit_val_o,
  output logic [31:0]       stage_o
);
  import wide_reg_pkg::*;
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             mapped;
  logic [31:0]      stage_q;

  assign idx    = addr[ADDR_W-1:3];
  assign mapped = (int'(idx) < NUM_SLOTS);

  assign commit_o     = wr && mapped && addr[2];
  assign commit_idx_o = idx;
  assign commit_val_o = join_halves(stage_q, wdata);
  assign stage_o      = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           stage_q <= '0;
    else if (clr)                         stage_q <= '0;
    else if (wr && mapped && !addr[2])    stage_q <= wdata;
    else if (commit_o)                    stage_q <= '0;
  end
endmodule

// File: rtl/split_read.sv
module split_read #(
  parameter int ADDR_W = 5,
  parameter int SLOTS  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  rd,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [SLOTS-1:0][63:0] live_i,
  output logic [31:0]           rdata_o,
  output logic                  shadow_vld_o
);
  import wide_reg_pkg::*;
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             mapped;
  logic [63:0]      sel;
  logic [31:0]      shadow_q;
  logic             vld_q;

  assign idx    = addr[ADDR_W-1:3];
  assign mapped = (int'(idx) < SLOTS);

  always_comb begin
    sel = '0;
    for (int s = 0; s < SLOTS; s++)
      if (int'(idx) == s) sel = live_i[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      shadow_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      if (rd) begin
        if (!mapped) begin
          rdata_o <= '0;
        end else if (!addr[2]) begin
          rdata_o  <= upper_of(sel);
          shadow_q <= lower_of(sel);
          vld_q    <= 1'b1;
        end else begin
          rdata_o <= vld_q ? shadow_q : lower_of(sel);
          vld_q   <= 1'b0;
        end
      end
      if (clr) vld_q <= 1'b0;
    end
  end

  assign shadow_vld_o = vld_q;
endmodule

// File: rtl/event_ctr.sv
module event_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         evt,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr)   cnt_o <= '0;
    else if (load)  cnt_o <= load_val;
    else if (evt)   cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int          ADDR_W       = 5,
  parameter logic [31:0] CTRL_LO_MASK = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_i,
  output logic              soft_rst_o
);
  import wide_reg_pkg::*;
  localparam int IDX_W = ADDR_W - 3;

  logic             commit_w;
  logic [IDX_W-1:0] commit_idx_w;
  logic [63:0]      commit_val_w;
  logic [31:0]      stage_w;
  logic             shadow_vld_w;
  logic             srst_w;
  logic             ctrl_commit_w, scr_commit_w, cnt_load_w;
  logic [31:0]      ctrl_hi_q, ctrl_lo_q;
  logic [63:0]      scr_q, cnt_w;
  logic [NUM_SLOTS-1:0][63:0] live_w;

  assign srst_w        = ctrl_lo_q[SRST_BIT];
  assign soft_rst_o    = srst_w;
  assign ctrl_commit_w = commit_w && (int'(commit_idx_w) == SLOT_CTRL);
  assign scr_commit_w  = commit_w && (int'(commit_idx_w) == SLOT_SCR);
  assign cnt_load_w    = commit_w && (int'(commit_idx_w) == SLOT_CNT);

  split_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr(srst_w), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .commit_o(commit_w), .commit_idx_o(commit_idx_w),
    .commit_val_o(commit_val_w), .stage_o(stage_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_hi_q <= '0;
      ctrl_lo_q <= '0;
    end else if (ctrl_commit_w) begin
      ctrl_hi_q <= upper_of(commit_val_w);
      ctrl_lo_q <= ctrl_lo_keep(lower_of(commit_val_w), CTRL_LO_MASK);
    end else if (srst_w) begin
      ctrl_lo_q[SRST_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            scr_q <= '0;
    else if (srst_w)       scr_q <= '0;
    else if (scr_commit_w) scr_q <= commit_val_w;
  end

  event_ctr #(.W(64)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(srst_w), .load(cnt_load_w),
    .load_val(commit_val_w), .evt(evt_i), .cnt_o(cnt_w)
  );

  assign live_w[SLOT_CTRL] = join_halves(ctrl_hi_q, ctrl_lo_q);
  assign live_w[SLOT_SCR]  = scr_q;
  assign live_w[SLOT_CNT]  = cnt_w;

  split_read #(.ADDR_W(ADDR_W), .SLOTS(NUM_SLOTS)) u_read (
    .clk(clk), .rst_n(rst_n), .clr(srst_w), .rd(bus_rd), .addr(bus_addr),
    .live_i(live_w), .rdata_o(bus_rdata), .shadow_vld_o(shadow_vld_w)
  );
endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              evt_i,
  input logic              soft_rst_o,
  input logic              commit_w,
  input logic              scr_commit_w,
  input logic              cnt_load_w,
  input logic [63:0]       commit_val_w,
  input logic [31:0]       stage_w,
  input logic              shadow_vld_w,
  input logic [63:0]       scr_q,
  input logic [63:0]       cnt_w
);
  logic mapped;
  assign mapped = (int'(bus_addr[ADDR_W-1:3]) < 3);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  a_r4_stage_clears: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> (stage_w == 32'h0));

  a_r3_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_commit_w && !soft_rst_o) |=> (scr_q == $past(commit_val_w)));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !cnt_load_w && !soft_rst_o) |=> (cnt_w == $past(cnt_w) + 64'd1));

  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !cnt_load_w && !soft_rst_o) |=> $stable(cnt_w));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load_w && !soft_rst_o) |=> (cnt_w == $past(commit_val_w)));

  a_r5_shadow_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && mapped && !bus_addr[2] && !soft_rst_o) |=> shadow_vld_w);

  a_r6_shadow_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && mapped && bus_addr[2]) |=> !shadow_vld_w);

  a_r10_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (cnt_w == 64'h0 && scr_q == 64'h0));
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr), .evt_i(evt_i),
  .soft_rst_o(soft_rst_o), .commit_w(commit_w), .scr_commit_w(scr_commit_w),
  .cnt_load_w(cnt_load_w), .commit_val_w(commit_val_w), .stage_w(stage_w),
  .shadow_vld_w(shadow_vld_w), .scr_q(scr_q), .cnt_w(cnt_w)
);

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, evt_i = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        soft_rst_o;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wide_reg_bridge i_wide_reg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .soft_rst_o(soft_rst_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 soft_rst_o", {31'h0, soft_rst_o}, 32'h0);
    for (int a = 0; a < 24; a += 4) begin
      rd32(5'(a), d);
      check("R1 reg zero", d, 32'h0);
    end
  endtask

  task automatic test_stage_commit();
    logic [31:0] d;
    wr32(5'h08, 32'hCAFE_0001);
    rd32(5'h0C, d); check("R2 stage not live lo", d, 32'h0);
    rd32(5'h08, d); check("R2 stage not live hi", d, 32'h0);
    wr32(5'h0C, 32'h1234_ABCD);
    rd32(5'h08, d); check("R3 commit hi", d, 32'hCAFE_0001);
    rd32(5'h0C, d); check("R3 commit lo", d, 32'h1234_ABCD);
    wr32(5'h0C, 32'h0000_5555);
    rd32(5'h08, d); check("R4 lone lo write zeroes hi", d, 32'h0);
    rd32(5'h0C, d); check("R4 lone lo write lo", d, 32'h0000_5555);
  endtask

  task automatic test_coherent_read();
    logic [31:0] d;
    wr32(5'h14, 32'hFFFF_FFFF);
    rd32(5'h14, d); check("R7 lo without shadow", d, 32'hFFFF_FFFF);
    rd32(5'h10, d); check("R5 hi read", d, 32'h0);
    @(negedge clk); evt_i = 1'b1;
    @(negedge clk); evt_i = 1'b0;
    rd32(5'h14, d); check("R6 shadow returned", d, 32'hFFFF_FFFF);
    rd32(5'h14, d); check("R6 shadow spent, live lo", d, 32'h0);
    rd32(5'h10, d); check("R6 live hi after carry", d, 32'h1);
  endtask

  task automatic test_counting();
    logic [31:0] d;
    wr32(5'h14, 32'h0);
    @(negedge clk); evt_i = 1'b1;
    repeat (5) @(negedge clk);
    evt_i = 1'b0;
    repeat (3) @(negedge clk);
    rd32(5'h10, d); check("R8 count hi", d, 32'h0);
    rd32(5'h14, d); check("R8 five events", d, 32'd5);
    wr32(5'h10, 32'h0000_0007);
    @(negedge clk); bus_addr = 5'h14; bus_wdata = 32'h0000_0100; bus_wr = 1'b1; evt_i = 1'b1;
    @(negedge clk); bus_wr = 1'b0; evt_i = 1'b0;
    rd32(5'h10, d); check("R9 load hi", d, 32'h7);
    rd32(5'h14, d); check("R9 load beats event", d, 32'h0000_0100);
  endtask

  task automatic test_ctrl_mask();
    logic [31:0] d;
    wr32(5'h00, 32'hA5A5_0F0F);
    wr32(5'h04, 32'h7FFF_FF3C);
    rd32(5'h00, d); check("R11 ctrl hi full", d, 32'hA5A5_0F0F);
    rd32(5'h04, d); check("R11 ctrl lo masked", d, 32'h0000_003C);
    check("R11 no reset pulse", {31'h0, soft_rst_o}, 32'h0);
  endtask

  task automatic test_soft_reset();
    logic [31:0] d;
    wr32(5'h08, 32'hDEAD_0001); wr32(5'h0C, 32'h0000_BEEF);
    wr32(5'h10, 32'h0000_0002); wr32(5'h14, 32'h0000_0003);
    wr32(5'h00, 32'h1234_5678);
    @(negedge clk); bus_addr = 5'h04; bus_wdata = 32'h8000_00A5; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R10 pulse high", {31'h0, soft_rst_o}, 32'h1);
    evt_i = 1'b1;
    @(negedge clk); evt_i = 1'b0;
    check("R10 pulse one cycle", {31'h0, soft_rst_o}, 32'h0);
    rd32(5'h08, d); check("R10 scratch hi cleared", d, 32'h0);
    rd32(5'h0C, d); check("R10 scratch lo cleared", d, 32'h0);
    rd32(5'h10, d); check("R10 counter hi cleared", d, 32'h0);
    rd32(5'h14, d); check("R10 counter lo cleared, event lost", d, 32'h0);
    rd32(5'h00, d); check("R10 ctrl hi kept", d, 32'h1234_5678);
    rd32(5'h04, d); check("R10 ctrl bit31 self-cleared", d, 32'h0000_00A5);
  endtask

  task automatic test_unmapped();
    logic [31:0] d;
    wr32(5'h08, 32'hAAAA_0000);
    wr32(5'h18, 32'hBBBB_0000);
    wr32(5'h1C, 32'h1111_2222);
    rd32(5'h18, d); check("R12 unmapped hi", d, 32'h0);
    rd32(5'h1C, d); check("R12 unmapped lo", d, 32'h0);
    wr32(5'h0C, 32'h0000_0042);
    rd32(5'h08, d); check("R12 stage untouched", d, 32'hAAAA_0000);
    rd32(5'h0C, d); check("R12 scratch lo", d, 32'h0000_0042);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_stage_commit();
    test_coherent_read();
    test_counting();
    test_ctrl_mask();
    test_soft_reset();
    test_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule